// File: doc/BRIEF.md
# Flash Interrupt and Status Unit

This block keeps the controller status word, the interrupt word and the two configuration words of a NAND flash controller. A 16-bit register port reads and writes these words. Separate completion inputs tell the block when a load, program or erase has finished and whether it failed. The block then sets the matching completion and error bits. From these words it drives an interrupt pin and a ready pin.

Command opcodes are written into the unit through the same register port. The unit holds a new opcode back while the master interrupt bit is still set. A recognised opcode goes out as a one-cycle command strobe to the execution logic. An unrecognised opcode is flagged as a command error. The two reset opcodes are handled locally as a warm reset of the register set. The flash array and the execution of commands sit outside this block.

Register select codes on `bus_addr` are: 0 status (read-only), 1 interrupt, 2 configuration word A, 3 configuration word B, 4 command. Any other code reads as zero and ignores writes.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After the active-low reset `rst_n`, the interrupt word reads 0x8080, configuration A reads 0x40C0, configuration B reads 0, status reads 0 and the command word reads 0; `irq` and `ready` are both 1.
- R2: Configuration A reads back ANDed with 0xFFE0; from the cycle after a write, `ready` equals bit 7 of configuration A.
- R3: `irq` equals interrupt bit 15 XOR the inverse of configuration A bit 6, and it follows a write to either word from the next clock edge.
- R4: A write to the interrupt word stores the bitwise AND of the written value and the old contents.
- R5: If an interrupt-word write leaves bit 15 clear, status bits 13..10 are all cleared; if bit 15 stays set, they are kept.
- R6: `done_valid` sets interrupt bit 15 and a kind bit chosen by `done_kind` (0 load: bit 7, 1 program: bit 6, 2 erase: bit 5, 3 reset: bit 4). With `done_err` it also sets status bit 10 plus a kind error bit (load: 13, program: 12, erase: 11, reset: none).
- R7: A command write while interrupt bit 15 is set changes nothing: the command word keeps its value and no strobe is issued.
- R8: A command write with bit 15 clear whose value is one of 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95 or 0xB0 stores the value and raises `cmd_valid` with `cmd_code` equal to the value for exactly the following cycle.
- R9: Any other accepted command value, except the reset opcodes, is stored and sets status bit 10 and interrupt bit 15, with no strobe.
- R10: An accepted command value of 0xF0 or 0xF3 warm-resets the words: interrupt 0x8010, configuration A 0x40C0, configuration B 0, status 0, command word 0, with no strobe.
- R11: When `done_valid` and an interrupt-word write fall in the same cycle, the write is applied first and the completion bits are then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| done_valid | input | 1 | An operation has finished |
| done_kind | input | 2 | Kind of finished operation |
| done_err | input | 1 | The finished operation failed |
| cmd_valid | output | 1 | One-cycle strobe for an accepted opcode |
| cmd_code | output | 8 | Opcode carried by the strobe |
| irq | output | 1 | Interrupt pin, polarity set by configuration |
| ready | output | 1 | Ready pin |

## Verification
Some properties are checked on every cycle. The specific error bits never stand without the command error bit. A completion always raises the master bit. An interrupt write that drops the master bit empties the error bits. The strobe appears only after a write that was accepted. The ready pin and the interrupt pin follow a configuration write. The opcode decoding, the exact reset and warm-reset values and the read-back masking are shown only by the bench's scenarios. So is the ordering when a completion meets an interrupt write in the same cycle.

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          done_valid,
  input  logic [1:0]    done_kind,
  input  logic          done_err,
  output logic          cmd_valid,
  output logic [7:0]    cmd_code,
  output logic          irq,
  output logic          ready
);
  localparam logic [AW-1:0] SEL_STAT = 0, SEL_INT = 1, SEL_CFGA = 2, SEL_CFGB = 3, SEL_CMD = 4;
  localparam logic [DW-1:0] INT_COLD = 16'h8080, INT_WARM = 16'h8010, CFGA_RST = 16'h40C0;
  localparam logic [DW-1:0] CFGA_RMASK = 16'hFFE0;
  localparam int MASTER = 15, ERR_CMD = 10;

  logic [DW-1:0] int_q, stat_q, cfga_q, cfgb_q, cmd_q;
  logic [DW-1:0] int_n, stat_n, cfga_n, cfgb_n, cmd_n;
  logic          cv_n;
  logic [7:0]    code_n;
  logic          known_op, reset_op;

  always_comb begin
    known_op = 1'b0;
    if (bus_wdata[15:8] == 8'h00)
      case (bus_wdata[7:0])
        8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
        8'h2C, 8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0: known_op = 1'b1;
        default: known_op = 1'b0;
      endcase
  end
  assign reset_op = (bus_wdata == 16'h00F0) || (bus_wdata == 16'h00F3);

  always_comb begin
    int_n  = int_q;
    stat_n = stat_q;
    cfga_n = cfga_q;
    cfgb_n = cfgb_q;
    cmd_n  = cmd_q;
    cv_n   = 1'b0;
    code_n = cmd_code;
    if (bus_wr) begin
      case (bus_addr)
        SEL_INT: begin
          int_n = int_q & bus_wdata;
          if (!int_n[MASTER]) stat_n[13:10] = 4'b0000;
        end
        SEL_CFGA: cfga_n = bus_wdata;
        SEL_CFGB: cfgb_n = bus_wdata;
        SEL_CMD: if (!int_q[MASTER]) begin
          if (reset_op) begin
            int_n  = INT_WARM;
            cfga_n = CFGA_RST;
            cfgb_n = '0;
            stat_n = '0;
            cmd_n  = '0;
          end else begin
            cmd_n = bus_wdata;
            if (known_op) begin
              cv_n   = 1'b1;
              code_n = bus_wdata[7:0];
            end else begin
              stat_n[ERR_CMD] = 1'b1;
              int_n[MASTER]   = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    if (done_valid) begin
      int_n[MASTER] = 1'b1;
      int_n[7 - done_kind] = 1'b1;
      if (done_err) begin
        stat_n[ERR_CMD] = 1'b1;
        if (done_kind != 2'd3) stat_n[13 - done_kind] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q     <= INT_COLD;
      stat_q    <= '0;
      cfga_q    <= CFGA_RST;
      cfgb_q    <= '0;
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      int_q     <= int_n;
      stat_q    <= stat_n;
      cfga_q    <= cfga_n;
      cfgb_q    <= cfgb_n;
      cmd_q     <= cmd_n;
      cmd_valid <= cv_n;
      cmd_code  <= code_n;
    end
  end

  always_comb
    case (bus_addr)
      SEL_STAT: bus_rdata = stat_q;
      SEL_INT:  bus_rdata = int_q;
      SEL_CFGA: bus_rdata = cfga_q & CFGA_RMASK;
      SEL_CFGB: bus_rdata = cfgb_q;
      SEL_CMD:  bus_rdata = cmd_q;
      default:  bus_rdata = '0;
    endcase

  assign irq   = int_q[MASTER] ^ ~cfga_q[6];
  assign ready = cfga_q[7];
endmodule

module flash_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        done_valid,
  input logic        cmd_valid,
  input logic        irq,
  input logic        ready,
  input logic [15:0] int_q,
  input logic [15:0] stat_q
);
  assert_err_has_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[13:11] != 3'b000) |-> stat_q[10]);

  assert_done_sets_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> int_q[15]);

  assert_clear_errors_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && !bus_wdata[15] && !done_valid) |=> (stat_q[13:10] == 4'b0000));

  assert_strobe_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(bus_wr && bus_addr == 3'd4 && !int_q[15]));

  assert_blocked_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && int_q[15]) |=> !cmd_valid);

  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2) |=> (ready == $past(bus_wdata[7])));

  assert_irq_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !done_valid) |=> (irq == ($past(int_q[15]) ^ ~$past(bus_wdata[6]))));
endmodule

bind flash_irq_status_unit flash_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .done_valid(done_valid), .cmd_valid(cmd_valid), .irq(irq), .ready(ready),
  .int_q(int_q), .stat_q(stat_q)
);

// File: tb/tb_flash_irq_status_unit.sv
module tb_flash_irq_status_unit;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        done_valid = 0, done_err = 0;
  logic [1:0]  done_kind = 0;
  logic        cmd_valid, irq, ready;
  logic [7:0]  cmd_code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done_valid(done_valid), .done_kind(done_kind), .done_err(done_err),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq(irq), .ready(ready)
  );

  localparam logic [2:0] A_STAT = 0, A_INT = 1, A_CFGA = 2, A_CFGB = 3, A_CMD = 4;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic done(logic [1:0] k, logic e);
    @(negedge clk);
    done_valid = 1; done_kind = k; done_err = e;
    @(posedge clk); #1;
    done_valid = 0; done_err = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 int", A_INT, 16'h8080);
    rd_chk("R1 cfgA", A_CFGA, 16'h40C0);
    rd_chk("R1 cfgB", A_CFGB, 16'h0000);
    rd_chk("R1 stat", A_STAT, 16'h0000);
    rd_chk("R1 cmd", A_CMD, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'd1);
    chk("R1 ready", {15'b0, ready}, 16'd1);
  endtask

  task automatic t_blocked;
    wr(A_CMD, 16'h0000);
    chk("R7 no strobe", {15'b0, cmd_valid}, 16'd0);
    wr(A_CMD, 16'h0094);
    chk("R7 no strobe 2", {15'b0, cmd_valid}, 16'd0);
    rd_chk("R7 cmd kept", A_CMD, 16'h0000);
  endtask

  task automatic t_and_clear;
    wr(A_INT, 16'hFF7F);
    rd_chk("R4 and keep", A_INT, 16'h8000);
    wr(A_INT, 16'h0000);
    rd_chk("R4 and zero", A_INT, 16'h0000);
    chk("R3 irq low", {15'b0, irq}, 16'd0);
  endtask

  task automatic t_cfga;
    wr(A_CFGA, 16'h00FF);
    rd_chk("R2 mask", A_CFGA, 16'h00E0);
    chk("R2 ready hi", {15'b0, ready}, 16'd1);
    wr(A_CFGA, 16'h0040);
    chk("R2 ready lo", {15'b0, ready}, 16'd0);
    chk("R3 irq 0^0", {15'b0, irq}, 16'd0);
    wr(A_CFGA, 16'h0000);
    chk("R3 irq inverted", {15'b0, irq}, 16'd1);
    wr(A_CFGA, 16'h40C0);
    chk("R3 irq back", {15'b0, irq}, 16'd0);
  endtask

  task automatic t_accept;
    wr(A_CMD, 16'h0094);
    chk("R8 strobe", {15'b0, cmd_valid}, 16'd1);
    chk("R8 code", {8'b0, cmd_code}, 16'h0094);
    rd_chk("R8 cmd word", A_CMD, 16'h0094);
    @(posedge clk); #1;
    chk("R8 one cycle", {15'b0, cmd_valid}, 16'd0);
    wr(A_CMD, 16'h001B);
    chk("R8 code 2", {7'b0, cmd_valid, cmd_code}, 16'h011B);
  endtask

  task automatic t_done_err;
    done(2'd2, 1'b1);
    rd_chk("R6 erase int", A_INT, 16'h8020);
    rd_chk("R6 erase err", A_STAT, 16'h0C00);
    chk("R3 irq pending", {15'b0, irq}, 16'd1);
    wr(A_CMD, 16'h0080);
    chk("R7 blocked strobe", {15'b0, cmd_valid}, 16'd0);
    rd_chk("R7 blocked cmd", A_CMD, 16'h001B);
    wr(A_INT, 16'hFFFF);
    rd_chk("R5 keep errors", A_STAT, 16'h0C00);
    wr(A_INT, 16'h7FFF);
    rd_chk("R5 int after", A_INT, 16'h0020);
    rd_chk("R5 errors cleared", A_STAT, 16'h0000);
    done(2'd0, 1'b0);
    rd_chk("R6 load ok", A_INT, 16'h80A0);
    rd_chk("R6 load no err", A_STAT, 16'h0000);
    wr(A_INT, 16'h0000);
    done(2'd1, 1'b1);
    rd_chk("R6 prog int", A_INT, 16'h8040);
    rd_chk("R6 prog err", A_STAT, 16'h1400);
    wr(A_INT, 16'h0000);
    done(2'd0, 1'b1);
    rd_chk("R6 load err", A_STAT, 16'h2400);
    wr(A_INT, 16'h0000);
    done(2'd3, 1'b1);
    rd_chk("R6 reset kind int", A_INT, 16'h8010);
    rd_chk("R6 reset kind err", A_STAT, 16'h0400);
    wr(A_INT, 16'h0000);
  endtask

  task automatic t_unknown;
    wr(A_CMD, 16'h0055);
    chk("R9 no strobe", {15'b0, cmd_valid}, 16'd0);
    rd_chk("R9 stat", A_STAT, 16'h0400);
    rd_chk("R9 int", A_INT, 16'h8000);
    rd_chk("R9 cmd word", A_CMD, 16'h0055);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0194);
    chk("R9 high byte", {15'b0, cmd_valid}, 16'd0);
    rd_chk("R9 high byte stat", A_STAT, 16'h0400);
    wr(A_INT, 16'h0000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    bus_wr = 1; bus_addr = A_INT; bus_wdata = 16'h0000;
    done_valid = 1; done_kind = 2'd1; done_err = 1;
    @(posedge clk); #1;
    bus_wr = 0; done_valid = 0; done_err = 0;
    rd_chk("R11 int", A_INT, 16'h8040);
    rd_chk("R11 stat", A_STAT, 16'h1400);
    wr(A_INT, 16'h0000);
  endtask

  task automatic t_warm;
    wr(A_CFGB, 16'h1234);
    wr(A_CFGA, 16'h0000);
    wr(A_CMD, 16'h00F3);
    chk("R10 no strobe", {15'b0, cmd_valid}, 16'd0);
    rd_chk("R10 int", A_INT, 16'h8010);
    rd_chk("R10 cfgA", A_CFGA, 16'h40C0);
    rd_chk("R10 cfgB", A_CFGB, 16'h0000);
    rd_chk("R10 stat", A_STAT, 16'h0000);
    rd_chk("R10 cmd", A_CMD, 16'h0000);
    wr(A_INT, 16'h0000);
    wr(A_CFGB, 16'h00AA);
    wr(A_CMD, 16'h00F0);
    rd_chk("R10 F0 int", A_INT, 16'h8010);
    rd_chk("R10 F0 cfgB", A_CFGB, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_blocked();
    t_and_clear();
    t_cfga();
    t_accept();
    t_done_err();
    t_unknown();
    t_same_cycle();
    t_warm();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule